// File: doc/BRIEF.md
# Vector Length Control Unit

This unit keeps the two lengths that govern a vector loop: a maximum length and a current length. Each is held in a 6-bit register whose all-zero code stands for the full length of 64, so both always hold a legal value from 1 to 64. A single request port accepts one operation at a time: a read of either length, a full register write, a short-immediate write, or the set-length operation. Set-length trims a requested count to the maximum and hands back the length actually granted.

A small sequencer runs every request. It has three states: `ST_IDLE`, `ST_UPDATE` and `ST_REPLY`. While in `ST_IDLE` the unit raises `req_ready`. An accepted request moves it to `ST_UPDATE`, where the registers take their new values. It then moves to `ST_REPLY`, where `rsp_valid` is high for one cycle with the decoded result. After that it returns to `ST_IDLE`. Responses always show the 1..64 value, never the raw stored code.

Top module: `vlen_ctrl`

## Requirements
- R1: After reset, both the current and the maximum length read as 64, and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is then high for exactly one cycle, two clocks after acceptance. `req_ready` stays low from acceptance until that reply has ended.
- R3: Op code 0 reads the current length and op code 1 reads the maximum. Each returns a value from 1 to 64 and changes neither register.
- R4: Op code 2 writes the current length from `req_data[5:0]`, and higher data bits are ignored. A code of 0 means 64. The stored value is the smaller of that length and the maximum, and the reply returns the stored value.
- R5: Op code 3 (current length) and op code 5 (maximum) write from `req_data[4:0]` only. A code of 0 means 64. Op code 3 is limited to the maximum. Each returns the new value of the register it writes.
- R6: Op code 4 writes the maximum from `req_data[5:0]`, with 0 meaning 64. If the current length is above the new maximum, the current length is lowered to it. The reply returns the new maximum.
- R7: Op code 6 (set-length) takes the whole 16-bit `req_data` as the requested count. It stores and returns the smaller of that count and the maximum. A count of 0 yields 1.
- R8: The current length never exceeds the maximum.
- R9: Op code 7 changes no register and returns the current length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit is idle and can take a request |
| req_op | input | 3 | Operation code |
| req_data | input | 16 | Write data, immediate, or requested count |
| rsp_valid | output | 1 | Reply strobe, one cycle |
| rsp_data | output | 7 | Decoded length from 1 to 64 |

## Verification
Set-length is swept over every requested count from 0 to 66, plus the all-ones count, under each of the 64 maximum codes. This sweep tells apart the zero floor, the pass-through region and the clamp region, and it shows that the upper request bits are honoured. Register writes are swept over every 6-bit code with junk in the upper bits, under both a reduced and the full maximum. This separates the zero-to-64 mapping from the clamp and shows that the extra bits are dropped. Immediate writes run all 32 codes with bits 5 and up set, which confirms that only five bits reach the register. Lowering the maximum below a full current length, and sending the spare op code, show the shrink rule and the no-effect rule.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
    typedef enum logic [2:0] {
        OP_RD_LEN  = 3'd0,
        OP_RD_MAX  = 3'd1,
        OP_WR_LEN  = 3'd2,
        OP_WRI_LEN = 3'd3,
        OP_WR_MAX  = 3'd4,
        OP_WRI_MAX = 3'd5,
        OP_SET_LEN = 3'd6,
        OP_RSVD    = 3'd7
    } vlen_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UPDATE = 2'd1,
        ST_REPLY  = 2'd2
    } vlen_state_e;
endpackage

// File: rtl/vlen_clamp.sv
module vlen_clamp #(
    parameter int LEN_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] want,
    input  logic [LEN_W:0]    limit,
    output logic [LEN_W:0]    result
);
    localparam int DEC_W = LEN_W + 1;

    always_comb begin
        if (want == '0)
            result = DEC_W'(1);
        else if (want > DATA_W'(limit))
            result = limit;
        else
            result = want[DEC_W-1:0];
    end
endmodule

// File: rtl/vlen_seq.sv
module vlen_seq
    import vlen_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              upd_en,
    output logic              rsp_valid,
    output vlen_op_e          op_q,
    output logic [DATA_W-1:0] data_q
);
    vlen_state_e state_q, state_d;
    logic        accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        upd_en    = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_UPDATE: upd_en    = 1'b1;
            ST_REPLY:  rsp_valid = 1'b1;
            default:   ;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_RD_LEN;
            data_q <= '0;
        end else if (accept) begin
            op_q   <= vlen_op_e'(req_op);
            data_q <= req_data;
        end
    end
endmodule

// File: rtl/vlen_store.sv
module vlen_store
    import vlen_pkg::*;
#(
    parameter int LEN_W  = 6,
    parameter int DATA_W = 16,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  vlen_op_e          op,
    input  logic [DATA_W-1:0] data,
    output logic [LEN_W:0]    len_dec,
    output logic [LEN_W:0]    max_dec
);
    localparam int DEC_W = LEN_W + 1;
    localparam logic [DEC_W-1:0] FULL = {1'b1, {LEN_W{1'b0}}};

    function automatic logic [DEC_W-1:0] expand(input logic [LEN_W-1:0] raw);
        return (raw == '0) ? FULL : {1'b0, raw};
    endfunction

    logic [LEN_W-1:0]  len_q, max_q;
    logic [LEN_W-1:0]  imm_raw;
    logic [DEC_W-1:0]  reg_val, imm_val, new_max, len_fit, len_shrunk;
    logic [DATA_W-1:0] len_want;

    assign imm_raw = LEN_W'(data[IMM_W-1:0]);
    assign reg_val = expand(data[LEN_W-1:0]);
    assign imm_val = expand(imm_raw);
    assign len_dec = expand(len_q);
    assign max_dec = expand(max_q);
    assign new_max = (op == OP_WR_MAX) ? reg_val : imm_val;

    always_comb begin
        unique case (op)
            OP_WR_LEN:  len_want = DATA_W'(reg_val);
            OP_WRI_LEN: len_want = DATA_W'(imm_val);
            default:    len_want = data;
        endcase
    end

    vlen_clamp #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_fit (
        .want   (len_want),
        .limit  (max_dec),
        .result (len_fit)
    );

    vlen_clamp #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_shrink (
        .want   (DATA_W'(len_dec)),
        .limit  (new_max),
        .result (len_shrunk)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            max_q <= '0;
        end else if (upd_en) begin
            unique case (op)
                OP_WR_LEN, OP_WRI_LEN, OP_SET_LEN:
                    len_q <= len_fit[LEN_W-1:0];
                OP_WR_MAX, OP_WRI_MAX: begin
                    max_q <= new_max[LEN_W-1:0];
                    len_q <= len_shrunk[LEN_W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
    import vlen_pkg::*;
#(
    parameter int LEN_W  = 6,
    parameter int DATA_W = 16,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [LEN_W:0]    rsp_data
);
    logic              upd_en;
    vlen_op_e          op_q;
    logic [DATA_W-1:0] data_q;
    logic [LEN_W:0]    len_dec, max_dec, pick;

    vlen_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_data  (req_data),
        .req_ready (req_ready),
        .upd_en    (upd_en),
        .rsp_valid (rsp_valid),
        .op_q      (op_q),
        .data_q    (data_q)
    );

    vlen_store #(.LEN_W(LEN_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .op      (op_q),
        .data    (data_q),
        .len_dec (len_dec),
        .max_dec (max_dec)
    );

    always_comb begin
        unique case (op_q)
            OP_RD_MAX, OP_WR_MAX, OP_WRI_MAX: pick = max_dec;
            default:                          pick = len_dec;
        endcase
    end

    assign rsp_data = rsp_valid ? pick : '0;
endmodule

// File: rtl/vlen_ctrl_chk.sv
module vlen_ctrl_chk #(
    parameter int LEN_W = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic [LEN_W:0] rsp_data,
    input logic [LEN_W:0] len_dec,
    input logic [LEN_W:0] max_dec
);
    localparam logic [LEN_W:0] FULL = {1'b1, {LEN_W{1'b0}}};

    // R8
    len_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_dec <= max_dec);

    // R2
    reply_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);

    // R2
    reply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R3
    rsp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data >= 1 && rsp_data <= FULL));
endmodule

bind vlen_ctrl vlen_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .len_dec   (len_dec),
    .max_dec   (max_dec)
);

// File: tb/sim_vlen_ctrl.sv
module sim_vlen_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [15:0] req_data = '0;
    logic        rsp_valid;
    logic [6:0]  rsp_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int mlen = 64;
    int mmax = 64;
    bit finished = 0;

    always #4 clk = ~clk;

    vlen_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_data  (req_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int dec(input int code, input int full);
        return (code == 0) ? full : code;
    endfunction

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // arithmetic model of the requirements; returns expected reply
    function automatic int model(input int op, input int d);
        int v;
        case (op)
            0: return mlen;
            1: return mmax;
            2: begin v = dec(d % 64, 64); mlen = min2(v, mmax); return mlen; end
            3: begin v = dec(d % 32, 64); mlen = min2(v, mmax); return mlen; end
            4: begin mmax = dec(d % 64, 64); mlen = min2(mlen, mmax); return mmax; end
            5: begin mmax = dec(d % 32, 64); mlen = min2(mlen, mmax); return mmax; end
            6: begin mlen = (d == 0) ? 1 : min2(d, mmax); return mlen; end
            default: return mlen;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1:    return "R3";
            2:       return "R4";
            3, 5:    return "R5";
            4:       return "R6";
            6:       return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic run(input int op, input int d);
        int exp;
        int n;
        exp = model(op, d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_data  = 16'(d);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_valid && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(tag_of(op), int'(rsp_data), exp);
        check("R2 delay", n, 2);
        check("R2 busy", int'(req_ready), 0);
    endtask

    task automatic read_both(output int l, output int m);
        run(0, 0); l = int'(rsp_data);
        run(1, 0); m = int'(rsp_data);
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int l, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", int'(req_ready), 1);
        read_both(l, m);
        check("R1 len", l, 64);
        check("R1 max", m, 64);

        // R7 set-length sweep over every maximum code
        for (int mc = 0; mc < 64; mc++) begin
            run(4, mc | 16'h5A00);
            for (int r = 0; r <= 66; r++) run(6, r);
            run(6, 16'hFFFF);
            run(0, 0);
        end

        // R6 lowering the maximum shrinks a full length; R8
        run(4, 0);
        run(2, 0);
        run(4, 40);
        read_both(l, m);
        check("R6 shrink", l, 40);
        check("R8 len<=max", int'(l <= m), 1);

        // R4 register write sweep, reduced and full maximum
        for (int c = 0; c < 64; c++) run(2, c | (16'hA5 << 6));
        run(4, 0);
        for (int c = 0; c < 64; c++) run(2, c | (16'hA5 << 6));

        // R5 immediate writes, upper bits set
        run(4, 0);
        for (int c = 0; c < 32; c++) run(3, c | 16'hFFE0);
        for (int c = 0; c < 32; c++) begin
            run(5, c | 16'hFFE0);
            read_both(l, m);
            check("R8 len<=max", int'(l <= m), 1);
        end

        // R9 spare op leaves state alone
        run(4, 50);
        run(6, 33);
        run(7, 16'h1234);
        read_both(l, m);
        check("R9 len kept", l, 33);
        check("R9 max kept", m, 50);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule